// File: doc/BRIEF.md
# Per-Zone Programmable Bus Cycle Sequencer

This block runs one access on an asynchronous external bus with separate address and data lines. Each access is a read or a write to one of several zones. It passes through three phases. The setup phase comes first and asserts chip select and direction. The strobe phase follows, with the read or write strobe held low. The hold phase keeps chip select and direction valid after the strobe rises. Every zone stores its own setup, strobe and hold lengths, one set for reads and one for writes. It also stores a flag that lets an external ready line stretch the strobe phase.

All phase timing counts ticks of a timing enable. One global rate setting chooses a tick on every clock or on every second clock. A requester raises `reqValid` together with the direction and zone. It holds them until `ack` pulses, then drops `reqValid`. The block does not accept configuration writes while an access is in flight, so the timing of an access cannot change part way through.

Top module: `zone_bus_seq`

## Requirements
- R1: After reset, `csEn`, `busy`, `ack` and `dataOe` are 0, and `rdStrobeN`, `wrStrobeN` and `readNotWrite` are 1.
- R2: The setup, strobe and hold phases last max(N,1) ticks each. N is the programmed value for the accessed zone and direction. The strobe phase is the span where the access's strobe is low. The setup phase is the span before it where `csEn` is high, and the hold phase is the span after it.
- R3: `rdStrobeN` is low only during the strobe phase of a read, and `wrStrobeN` is low only during the strobe phase of a write. The other strobe stays high for the whole access.
- R4: `csEn` is high across all three phases. `readNotWrite` is 1 for a read and 0 for a write, and holds that value for the whole time `csEn` is high.
- R5: `dataOe` is high for every clock that `csEn` is high during a write. It is low during reads and while idle.
- R6: With `cfgHalfRate`=1 (written through `cfgRateWe`), a tick occurs every second clock and every phase lasts twice as many clocks. With 0, a tick occurs on every clock. An access starts only on a tick.
- R7: When the zone's ready flag is 1, `extReady` is sampled only after the programmed strobe count has expired. The strobe phase holds while `extReady` is 0. When the flag is 0, `extReady` has no effect.
- R8: `busy` is high from the clock the access is accepted until the hold phase ends. `ack` is high for exactly one clock, in the clock right after the last hold clock, when `csEn` is already low. A request still held high during that `ack` clock does not start a new access.
- R9: A zone timing write (`cfgWe`) or rate write (`cfgRateWe`) made while `busy` is high is discarded. Later accesses use the earlier values.
- R10: After reset, every count in every zone is 0, meaning 1 tick. The ready flags are 0 and the rate is one tick per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Access request, held until ack |
| reqWrite | input | 1 | 1 = write access, 0 = read access |
| reqZone | input | ZONE_W | Zone of the requested access |
| busy | output | 1 | Access in progress |
| ack | output | 1 | One-clock pulse when the access completes |
| cfgWe | input | 1 | Write timing for zone cfgZone |
| cfgZone | input | ZONE_W | Zone selected by a timing write |
| cfgReadyEn | input | 1 | Ready-stretch flag for the zone |
| cfgRdLead | input | CNT_W | Read setup ticks |
| cfgRdActive | input | CNT_W | Read strobe ticks |
| cfgRdTrail | input | CNT_W | Read hold ticks |
| cfgWrLead | input | CNT_W | Write setup ticks |
| cfgWrActive | input | CNT_W | Write strobe ticks |
| cfgWrTrail | input | CNT_W | Write hold ticks |
| cfgRateWe | input | 1 | Write the global rate setting |
| cfgHalfRate | input | 1 | 1 = tick every second clock |
| extReady | input | 1 | External ready, high = device ready |
| csEn | output | 1 | Chip-select enable, high during an access |
| rdStrobeN | output | 1 | Read strobe, active low |
| wrStrobeN | output | 1 | Write strobe, active low |
| readNotWrite | output | 1 | Direction, 1 = read |
| dataOe | output | 1 | Data bus output enable for writes |

## Verification
A phase counter loaded from the wrong zone or direction shows up in the first affected access as a setup, strobe or hold span of the wrong clock count. A stuck or skipped tick doubles or halves those spans. A state machine that leaves the strobe phase before ready rises, or never leaves it, gives a strobe length different from max(count, ready delay) or a hang. A configuration write that is not blocked during an access is seen in the next access to that zone, which runs with the new lengths instead of the old ones. Direction or enable errors show up as a mismatch on `readNotWrite`, `dataOe` or the idle strobe in the same clock.

// File: rtl/zseq_pkg.sv
package zseq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_LEAD  = 2'd1,
    PH_ACT   = 2'd2,
    PH_TRAIL = 2'd3
  } phase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;    // latch zone and direction of the request
    logic loadLead;   // load setup length
    logic loadAct;    // load strobe length
    logic loadTrail;  // load hold length
    logic countDown;  // decrement the phase counter
  } seqCtl_t;

endpackage

// File: rtl/zseq_datapath.sv
module zseq_datapath
  import zseq_pkg::*;
#(
  parameter int NUM_ZONES = 4,
  parameter int CNT_W     = 3,
  localparam int ZONE_W   = (NUM_ZONES > 1) ? $clog2(NUM_ZONES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCtl_t           ctl,
  input  logic              busy,
  input  logic              reqWrite,
  input  logic [ZONE_W-1:0] reqZone,
  input  logic              cfgWe,
  input  logic [ZONE_W-1:0] cfgZone,
  input  logic              cfgReadyEn,
  input  logic [CNT_W-1:0]  cfgRdLead,
  input  logic [CNT_W-1:0]  cfgRdActive,
  input  logic [CNT_W-1:0]  cfgRdTrail,
  input  logic [CNT_W-1:0]  cfgWrLead,
  input  logic [CNT_W-1:0]  cfgWrActive,
  input  logic [CNT_W-1:0]  cfgWrTrail,
  input  logic              cfgRateWe,
  input  logic              cfgHalfRate,
  output logic              tick,
  output logic              cntZero,
  output logic              curWrite,
  output logic              curReadyEn
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  typedef struct packed {
    logic             readyEn;
    logic [CNT_W-1:0] rdLead;
    logic [CNT_W-1:0] rdAct;
    logic [CNT_W-1:0] rdTrail;
    logic [CNT_W-1:0] wrLead;
    logic [CNT_W-1:0] wrAct;
    logic [CNT_W-1:0] wrTrail;
  } zoneCfg_t;

  zoneCfg_t [NUM_ZONES-1:0] zoneCfgQ;
  logic     [NUM_ZONES-1:0] zoneWe;
  zoneCfg_t                 cfgIn;
  logic                     halfQ;
  logic                     phaseT;
  logic [ZONE_W-1:0]        curZoneQ;
  logic                     curWriteQ;
  logic [CNT_W-1:0]         cntQ;

  logic [ZONE_W-1:0]        selZone;
  logic                     selWrite;
  zoneCfg_t                 selCfg;

  function automatic logic [CNT_W-1:0] lenM1(input logic [CNT_W-1:0] v);
    return (v == '0) ? '0 : v - CNT_ONE;
  endfunction

  assign cfgIn = '{readyEn: cfgReadyEn,
                   rdLead:  cfgRdLead,  rdAct: cfgRdActive, rdTrail: cfgRdTrail,
                   wrLead:  cfgWrLead,  wrAct: cfgWrActive, wrTrail: cfgWrTrail};

  // per-zone write enables, locked out during an access
  for (genvar z = 0; z < NUM_ZONES; z++) begin : g_zoneWe
    assign zoneWe[z] = cfgWe && !busy && (cfgZone == ZONE_W'(z));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      zoneCfgQ <= '0;
    end else begin
      for (int z = 0; z < NUM_ZONES; z++) begin
        if (zoneWe[z]) zoneCfgQ[z] <= cfgIn;
      end
    end
  end

  // global tick rate
  always_ff @(posedge clk) begin
    if (!rstN) begin
      halfQ  <= 1'b0;
      phaseT <= 1'b0;
    end else begin
      phaseT <= ~phaseT;
      if (cfgRateWe && !busy) halfQ <= cfgHalfRate;
    end
  end

  assign tick = !halfQ || phaseT;

  // captured access attributes
  always_ff @(posedge clk) begin
    if (!rstN) begin
      curZoneQ  <= '0;
      curWriteQ <= 1'b0;
    end else if (ctl.capture) begin
      curZoneQ  <= reqZone;
      curWriteQ <= reqWrite;
    end
  end

  assign selZone  = ctl.capture ? reqZone  : curZoneQ;
  assign selWrite = ctl.capture ? reqWrite : curWriteQ;
  assign selCfg   = zoneCfgQ[selZone];

  // phase counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (ctl.loadLead) begin
      cntQ <= lenM1(selWrite ? selCfg.wrLead : selCfg.rdLead);
    end else if (ctl.loadAct) begin
      cntQ <= lenM1(selWrite ? selCfg.wrAct : selCfg.rdAct);
    end else if (ctl.loadTrail) begin
      cntQ <= lenM1(selWrite ? selCfg.wrTrail : selCfg.rdTrail);
    end else if (ctl.countDown && cntQ != '0) begin
      cntQ <= cntQ - CNT_ONE;
    end
  end

  assign cntZero    = (cntQ == '0);
  assign curWrite   = curWriteQ;
  assign curReadyEn = zoneCfgQ[curZoneQ].readyEn;

  // R9: timing storage frozen while an access is in flight
  a_r9_zone_cfg_frozen : assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(zoneCfgQ));

  // R9: rate frozen while an access is in flight
  a_r9_rate_frozen : assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(halfQ));

  // R2: counter only moves on tick-qualified strobes from control
  a_r2_cnt_moves_on_ctl : assert property (@(posedge clk) disable iff (!rstN)
    (ctl == '0) |=> $stable(cntQ));

endmodule

// File: rtl/zseq_control.sv
module zseq_control
  import zseq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    extReady,
  input  logic    tick,
  input  logic    cntZero,
  input  logic    curWrite,
  input  logic    curReadyEn,
  output seqCtl_t ctl,
  output logic    busy,
  output logic    ack,
  output logic    csEn,
  output logic    rdStrobeN,
  output logic    wrStrobeN,
  output logic    readNotWrite,
  output logic    dataOe
);

  phase_t phaseQ;
  phase_t phaseD;
  logic   ackQ;
  logic   ackD;
  logic   readyOk;

  assign readyOk = !curReadyEn || extReady;

  always_comb begin
    phaseD = phaseQ;
    ctl    = '0;
    ackD   = 1'b0;
    unique case (phaseQ)
      PH_IDLE: begin
        if (reqValid && !ackQ && tick) begin
          ctl.capture  = 1'b1;
          ctl.loadLead = 1'b1;
          phaseD       = PH_LEAD;
        end
      end
      PH_LEAD: begin
        if (tick) begin
          if (cntZero) begin
            ctl.loadAct = 1'b1;
            phaseD      = PH_ACT;
          end else begin
            ctl.countDown = 1'b1;
          end
        end
      end
      PH_ACT: begin
        if (tick) begin
          if (!cntZero) begin
            ctl.countDown = 1'b1;
          end else if (readyOk) begin
            ctl.loadTrail = 1'b1;
            phaseD        = PH_TRAIL;
          end
        end
      end
      PH_TRAIL: begin
        if (tick) begin
          if (cntZero) begin
            ackD   = 1'b1;
            phaseD = PH_IDLE;
          end else begin
            ctl.countDown = 1'b1;
          end
        end
      end
      default: phaseD = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseQ <= PH_IDLE;
      ackQ   <= 1'b0;
    end else begin
      phaseQ <= phaseD;
      ackQ   <= ackD;
    end
  end

  assign busy         = (phaseQ != PH_IDLE);
  assign ack          = ackQ;
  assign csEn         = busy;
  assign rdStrobeN    = !((phaseQ == PH_ACT) && !curWrite);
  assign wrStrobeN    = !((phaseQ == PH_ACT) && curWrite);
  assign readNotWrite = busy ? !curWrite : 1'b1;
  assign dataOe       = busy && curWrite;

  // R8: acknowledge is a single-clock pulse
  a_r8_ack_single : assert property (@(posedge clk) disable iff (!rstN)
    ack |=> !ack);

  // R8: acknowledge only follows the hold phase
  a_r8_ack_after_trail : assert property (@(posedge clk) disable iff (!rstN)
    ack |-> ($past(phaseQ) == PH_TRAIL) && !csEn);

  // R4: direction stable while chip select is held
  a_r4_dir_stable : assert property (@(posedge clk) disable iff (!rstN)
    (csEn && $past(csEn)) |-> $stable(readNotWrite));

  // R6: no phase change between ticks
  a_r6_hold_between_ticks : assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> $stable(phaseQ));

  // R7: strobe phase held while enabled ready is low after count expiry
  a_r7_ready_holds : assert property (@(posedge clk) disable iff (!rstN)
    (phaseQ == PH_ACT && tick && cntZero && curReadyEn && !extReady) |=> (phaseQ == PH_ACT));

  // R3: strobes never low together
  a_r3_strobe_excl : assert property (@(posedge clk) disable iff (!rstN)
    rdStrobeN || wrStrobeN);

endmodule

// File: rtl/zone_bus_seq.sv
module zone_bus_seq
  import zseq_pkg::*;
#(
  parameter int NUM_ZONES = 4,
  parameter int CNT_W     = 3,
  localparam int ZONE_W   = (NUM_ZONES > 1) ? $clog2(NUM_ZONES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ZONE_W-1:0] reqZone,
  output logic              busy,
  output logic              ack,
  input  logic              cfgWe,
  input  logic [ZONE_W-1:0] cfgZone,
  input  logic              cfgReadyEn,
  input  logic [CNT_W-1:0]  cfgRdLead,
  input  logic [CNT_W-1:0]  cfgRdActive,
  input  logic [CNT_W-1:0]  cfgRdTrail,
  input  logic [CNT_W-1:0]  cfgWrLead,
  input  logic [CNT_W-1:0]  cfgWrActive,
  input  logic [CNT_W-1:0]  cfgWrTrail,
  input  logic              cfgRateWe,
  input  logic              cfgHalfRate,
  input  logic              extReady,
  output logic              csEn,
  output logic              rdStrobeN,
  output logic              wrStrobeN,
  output logic              readNotWrite,
  output logic              dataOe
);

  seqCtl_t ctl;
  logic    tick;
  logic    cntZero;
  logic    curWrite;
  logic    curReadyEn;

  zseq_datapath #(.NUM_ZONES(NUM_ZONES), .CNT_W(CNT_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .busy       (busy),
    .reqWrite   (reqWrite),
    .reqZone    (reqZone),
    .cfgWe      (cfgWe),
    .cfgZone    (cfgZone),
    .cfgReadyEn (cfgReadyEn),
    .cfgRdLead  (cfgRdLead),
    .cfgRdActive(cfgRdActive),
    .cfgRdTrail (cfgRdTrail),
    .cfgWrLead  (cfgWrLead),
    .cfgWrActive(cfgWrActive),
    .cfgWrTrail (cfgWrTrail),
    .cfgRateWe  (cfgRateWe),
    .cfgHalfRate(cfgHalfRate),
    .tick       (tick),
    .cntZero    (cntZero),
    .curWrite   (curWrite),
    .curReadyEn (curReadyEn)
  );

  zseq_control u_ctl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .extReady    (extReady),
    .tick        (tick),
    .cntZero     (cntZero),
    .curWrite    (curWrite),
    .curReadyEn  (curReadyEn),
    .ctl         (ctl),
    .busy        (busy),
    .ack         (ack),
    .csEn        (csEn),
    .rdStrobeN   (rdStrobeN),
    .wrStrobeN   (wrStrobeN),
    .readNotWrite(readNotWrite),
    .dataOe      (dataOe)
  );

endmodule

// File: tb/zone_bus_seq_tb.sv
module zone_bus_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_ZONES  = 4;
  localparam int CNT_W      = 3;
  localparam int ZONE_W     = 2;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic              reqWrite = 1'b0;
  logic [ZONE_W-1:0] reqZone = '0;
  logic              busy, ack;
  logic              cfgWe = 1'b0;
  logic [ZONE_W-1:0] cfgZone = '0;
  logic              cfgReadyEn = 1'b0;
  logic [CNT_W-1:0]  cfgRdLead = '0, cfgRdActive = '0, cfgRdTrail = '0;
  logic [CNT_W-1:0]  cfgWrLead = '0, cfgWrActive = '0, cfgWrTrail = '0;
  logic              cfgRateWe = 1'b0;
  logic              cfgHalfRate = 1'b0;
  logic              extReady = 1'b1;
  logic              csEn, rdStrobeN, wrStrobeN, readNotWrite, dataOe;

  int nChecks = 0;
  int nFails  = 0;

  // bench model of the configuration
  int mLead[2][NUM_ZONES];
  int mAct[2][NUM_ZONES];
  int mTrail[2][NUM_ZONES];
  bit mRdy[NUM_ZONES];
  bit mHalf;

  zone_bus_seq #(.NUM_ZONES(NUM_ZONES), .CNT_W(CNT_W)) u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int eLen(int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tickClk();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic writeZone(int z, bit rdy, int rl, int ra, int rt, int wl, int wa, int wt);
    cfgWe = 1'b1; cfgZone = ZONE_W'(z); cfgReadyEn = rdy;
    cfgRdLead = CNT_W'(rl); cfgRdActive = CNT_W'(ra); cfgRdTrail = CNT_W'(rt);
    cfgWrLead = CNT_W'(wl); cfgWrActive = CNT_W'(wa); cfgWrTrail = CNT_W'(wt);
    tickClk();
    cfgWe = 1'b0;
    mRdy[z] = rdy;
    mLead[0][z] = rl; mAct[0][z] = ra; mTrail[0][z] = rt;
    mLead[1][z] = wl; mAct[1][z] = wa; mTrail[1][z] = wt;
  endtask

  task automatic writeRate(bit h);
    cfgRateWe = 1'b1; cfgHalfRate = h;
    tickClk();
    cfgRateWe = 1'b0;
    mHalf = h;
  endtask

  // One access; rdyDelay>0 holds extReady low until the strobe has been low that many clocks.
  // poke=1 issues blocked configuration writes during the setup phase (R9).
  task automatic doAccess(int z, bit wr, int rdyDelay, bit poke);
    int  leadC = 0, actC = 0, trailC = 0, guard = 0;
    bit  done = 0, poked = 0;
    int  mult = mHalf ? 2 : 1;
    int  expAct;
    bit  ownLow, otherLow;
    reqValid = 1'b1; reqWrite = wr; reqZone = ZONE_W'(z);
    extReady = (rdyDelay > 0) ? 1'b0 : 1'b1;
    while (!done && guard < 400) begin
      tickClk();
      guard++;
      if (cfgWe || cfgRateWe) begin cfgWe = 1'b0; cfgRateWe = 1'b0; end
      ownLow   = wr ? !wrStrobeN : !rdStrobeN;
      otherLow = wr ? !rdStrobeN : !wrStrobeN;
      if (csEn) begin
        check(!otherLow, "R3 other strobe high", int'(otherLow), 0);
        check(readNotWrite == !wr, "R4 direction", int'(readNotWrite), int'(!wr));
        check(dataOe == wr, "R5 data enable", int'(dataOe), int'(wr));
        check(busy, "R8 busy during access", int'(busy), 1);
        if (ownLow) begin
          check(trailC == 0, "R3 single strobe window", trailC, 0);
          actC++;
          if (rdyDelay > 0 && actC == rdyDelay) extReady = 1'b1;
        end else if (actC == 0) begin
          leadC++;
          if (poke && !poked) begin
            poked = 1;
            cfgWe = 1'b1; cfgZone = ZONE_W'(z); cfgReadyEn = ~mRdy[z];
            cfgRdLead = '1; cfgRdActive = '1; cfgRdTrail = '1;
            cfgWrLead = '1; cfgWrActive = '1; cfgWrTrail = '1;
            cfgRateWe = 1'b1; cfgHalfRate = ~mHalf;
          end
        end else begin
          trailC++;
        end
      end else begin
        check(rdStrobeN && wrStrobeN, "R3 strobes idle high", int'({rdStrobeN, wrStrobeN}), 3);
        check(!dataOe, "R5 data enable idle", int'(dataOe), 0);
        if (leadC > 0) begin
          check(ack, "R8 ack after hold", int'(ack), 1);
          check(!busy, "R8 busy clear at ack", int'(busy), 0);
          done = 1;
        end else begin
          check(!ack, "R8 no ack before access", int'(ack), 0);
        end
      end
    end
    check(done, "R8 access completes", int'(done), 1);
    expAct = eLen(mAct[wr][z]);
    if (mRdy[z] && rdyDelay > 0 && !mHalf) expAct = imax(expAct, rdyDelay);
    check(leadC == mult * eLen(mLead[wr][z]), "R2/R6 setup length", leadC, mult * eLen(mLead[wr][z]));
    check(actC == mult * expAct, "R2/R7 strobe length", actC, mult * expAct);
    check(trailC == mult * eLen(mTrail[wr][z]), "R2/R6 hold length", trailC, mult * eLen(mTrail[wr][z]));
    // request still high during ack clock: must not retrigger (R8)
    reqValid = 1'b0;
    extReady = 1'b1;
    tickClk();
    check(!ack && !busy && !csEn, "R8 no retrigger after ack", int'({ack, busy, csEn}), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL R8 watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    for (int z = 0; z < NUM_ZONES; z++) begin
      mRdy[z] = 0;
      for (int d = 0; d < 2; d++) begin
        mLead[d][z] = 0; mAct[d][z] = 0; mTrail[d][z] = 0;
      end
    end
    mHalf = 0;
    repeat (3) tickClk();
    // R1: reset state
    check(!csEn && !busy && !ack && !dataOe, "R1 reset low outputs",
          int'({csEn, busy, ack, dataOe}), 0);
    check(rdStrobeN && wrStrobeN && readNotWrite, "R1 reset high outputs",
          int'({rdStrobeN, wrStrobeN, readNotWrite}), 7);
    rstN = 1'b1;
    tickClk();
    // R10: defaults give one tick per phase, ready ignored, full rate
    doAccess(0, 0, 5, 0);
    doAccess(3, 1, 0, 0);

    // R2: distinct read and write timing per zone
    writeZone(1, 0, 2, 3, 4, 5, 1, 2);
    doAccess(1, 0, 0, 0);
    doAccess(1, 1, 0, 0);
    // zero means one tick (R2)
    writeZone(2, 0, 0, 7, 0, 7, 0, 7);
    doAccess(2, 0, 0, 0);
    doAccess(2, 1, 0, 0);

    // R7: ready stretches only when enabled, sampled after count expiry
    writeZone(0, 1, 1, 2, 1, 1, 3, 1);
    doAccess(0, 0, 6, 0);
    doAccess(0, 1, 2, 0);
    doAccess(0, 1, 3, 0);
    doAccess(0, 1, 4, 0);
    writeZone(3, 0, 1, 2, 1, 1, 2, 1);
    doAccess(3, 0, 6, 0);

    // R9: writes during an access are discarded
    doAccess(1, 1, 0, 1);
    doAccess(1, 1, 0, 0);
    doAccess(1, 0, 0, 0);

    // R6: half rate
    writeRate(1);
    doAccess(1, 0, 0, 0);
    doAccess(2, 1, 0, 0);
    doAccess(0, 0, 0, 1);
    doAccess(0, 0, 0, 0);
    writeRate(0);

    // random mix
    for (int i = 0; i < 200; i++) begin
      int op = $urandom_range(0, 9);
      if (op == 0) begin
        writeZone($urandom_range(0, NUM_ZONES - 1), 1'($urandom_range(0, 1)),
                  $urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 7),
                  $urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 7));
      end else if (op == 1) begin
        writeRate(1'($urandom_range(0, 1)));
      end else begin
        int z  = $urandom_range(0, NUM_ZONES - 1);
        int dl = ($urandom_range(0, 2) == 0 || mHalf) ? 0 : $urandom_range(1, 10);
        doAccess(z, 1'($urandom_range(0, 1)), dl, 1'($urandom_range(0, 7) == 0));
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule